// File: doc/BRIEF.md
# Character LCD Nibble Sequencer

This block drives a two-line character LCD controller through a four-bit data bus together with a register-select line, a read/write line and an enable strobe. Once reset is released it runs the controller's power-up script without any request. The script sends three 0x3 nibbles and one 0x2 nibble to switch the controller into four-bit mode. It then sends five configuration commands: 0x28, 0x08, 0x01, 0x06 and 0x0C. After the script ends, the block raises its ready output.

A host then issues writes over a valid/ready handshake. Each write carries one byte and a flag that marks it as character data or as a command. The block sends the byte as two nibbles, high nibble first. Each nibble is set up on the bus, latched by an enable pulse, and followed by a settle time. A clear command or a return-home command gets a longer wait after it. All waits are timed by one down-counter. Every delay is a parameter in clock cycles, and its default value is derived from the clock frequency in kHz. Reads are not supported: the read/write line stays low.

Top module: `lcd4_seq`

## Requirements
- R1: While reset is asserted, `req_ready`, `lcd_en` and `lcd_rw` are low. The power-up script starts on its own when reset is released.
- R2: The script waits PWR_CYC cycles and then sends nibbles 0x3, 0x3, 0x3, 0x2 with RS low. The waits after these four nibbles are W4100_CYC, W100_CYC, NIB_CYC and NIB_CYC.
- R3: After the four nibbles, the script sends the command bytes 0x28, 0x08, 0x01, 0x06, 0x0C in that order, with RS low.
- R4: `req_ready` stays low from reset until the wait after the last script nibble has elapsed. It then rises.
- R5: Each accepted byte goes out as bits [7:4] first and then bits [3:0] on `lcd_db`. `lcd_rs` equals `req_rs`, where 1 means character data and 0 means command.
- R6: Data and RS are driven SU_CYC cycles before EN rises. EN stays high for exactly EN_CYC cycles. Data and RS do not change while EN is high.
- R7: After each nibble's falling EN edge, the block waits at least NIB_CYC cycles. Two nibbles of the same byte are therefore NIB_CYC+SU_CYC+EN_CYC cycles apart, measured between falling edges.
- R8: A command byte 0x01 extends the wait after its low nibble by CLR_CYC. A command byte 0x02 or 0x03 extends it by HOME_CYC. Data bytes with these same values get no extension.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls after that edge and stays low until the wait after the byte has ended. The first falling EN edge comes SU_CYC+EN_CYC cycles after the accepting edge.
- R10: `lcd_rw` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rs | input | 1 | 1 = character data, 0 = command |
| req_byte | input | 8 | Byte to write |
| lcd_db | output | 4 | Data bus, bits 7..4 of the controller |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read/write, held low |
| lcd_en | output | 1 | Enable strobe, data latched on falling edge |

## Verification
The bench counts rising clock edges from the release of reset. It samples all outputs at falling edges, and it logs every EN rise, every EN fall and every rise of ready with its edge number. The expected times follow from the counter model. The first script nibble falls at edge PWR_CYC+SU_CYC+EN_CYC, and each later fall comes at the previous fall plus its wait plus SU_CYC+EN_CYC. A request driven at a falling edge is accepted at the next rising edge. Its high nibble falls SU_CYC+EN_CYC edges after that, and ready comes back exactly one post-byte wait after the low nibble falls. Each logged time is compared with these values only after ready has risen again, so a check never depends on when it is sampled.

// File: rtl/lcd4_seq.sv
module lcd4_seq #(
  parameter int CLK_KHZ   = 125000,
  parameter int PWR_CYC   = CLK_KHZ * 20,
  parameter int W4100_CYC = CLK_KHZ * 41 / 10,
  parameter int W100_CYC  = CLK_KHZ / 10,
  parameter int NIB_CYC   = CLK_KHZ * 40 / 1000,
  parameter int CLR_CYC   = CLK_KHZ * 2,
  parameter int HOME_CYC  = CLK_KHZ * 16 / 10,
  parameter int EN_CYC    = (CLK_KHZ + 1999) / 2000,
  parameter int SU_CYC    = (CLK_KHZ + 9999) / 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic [7:0] req_byte,
  output logic [3:0] lcd_db,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en
);
  localparam int MAXC = PWR_CYC + W4100_CYC + NIB_CYC + CLR_CYC + HOME_CYC + EN_CYC + SU_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [3:0] LAST_STEP = 4'd9;

  typedef enum logic [2:0] {S_PWR, S_SETUP, S_EN, S_HOLD, S_IDLE} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [3:0]    step;
  logic          init, lo_pend, single;
  logic [7:0]    byte_q;
  logic [8:0]    sc_nxt;
  int            hold_c;

  function automatic logic [8:0] script(input logic [3:0] s);
    case (s)
      4'd1, 4'd2, 4'd3: return 9'h103;
      4'd4:             return 9'h102;
      4'd5:             return 9'h028;
      4'd6:             return 9'h008;
      4'd7:             return 9'h001;
      4'd8:             return 9'h006;
      default:          return 9'h00C;
    endcase
  endfunction

  assign sc_nxt    = script(state == S_PWR ? step : step + 4'd1);
  assign req_ready = (state == S_IDLE);
  assign lcd_rw    = 1'b0;

  always_comb begin
    hold_c = NIB_CYC;
    if (single && step == 4'd1)                          hold_c = W4100_CYC;
    else if (single && step == 4'd2)                     hold_c = W100_CYC;
    else if (!single && !lo_pend && !lcd_rs && byte_q == 8'h01)
      hold_c = NIB_CYC + CLR_CYC;
    else if (!single && !lo_pend && !lcd_rs && byte_q[7:1] == 7'h01)
      hold_c = NIB_CYC + HOME_CYC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PWR;
      cnt     <= CW'(PWR_CYC - 1);
      step    <= 4'd1;
      init    <= 1'b1;
      lo_pend <= 1'b0;
      single  <= 1'b0;
      byte_q  <= '0;
      lcd_db  <= '0;
      lcd_rs  <= 1'b0;
      lcd_en  <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (state)
        S_PWR: begin
          single  <= sc_nxt[8];
          byte_q  <= sc_nxt[7:0];
          lcd_rs  <= 1'b0;
          lcd_db  <= sc_nxt[8] ? sc_nxt[3:0] : sc_nxt[7:4];
          lo_pend <= !sc_nxt[8];
          cnt     <= CW'(SU_CYC - 1);
          state   <= S_SETUP;
        end
        S_SETUP: begin
          lcd_en <= 1'b1;
          cnt    <= CW'(EN_CYC - 1);
          state  <= S_EN;
        end
        S_EN: begin
          lcd_en <= 1'b0;
          cnt    <= CW'(hold_c - 1);
          state  <= S_HOLD;
        end
        S_HOLD: begin
          if (lo_pend) begin
            lcd_db  <= byte_q[3:0];
            lo_pend <= 1'b0;
            cnt     <= CW'(SU_CYC - 1);
            state   <= S_SETUP;
          end else if (init && step != LAST_STEP) begin
            step    <= step + 4'd1;
            single  <= sc_nxt[8];
            byte_q  <= sc_nxt[7:0];
            lcd_rs  <= 1'b0;
            lcd_db  <= sc_nxt[8] ? sc_nxt[3:0] : sc_nxt[7:4];
            lo_pend <= !sc_nxt[8];
            cnt     <= CW'(SU_CYC - 1);
            state   <= S_SETUP;
          end else begin
            init  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: begin
          if (req_valid) begin
            single  <= 1'b0;
            byte_q  <= req_byte;
            lcd_rs  <= req_rs;
            lcd_db  <= req_byte[7:4];
            lo_pend <= 1'b1;
            cnt     <= CW'(SU_CYC - 1);
            state   <= S_SETUP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd4_seq_chk.sv
module lcd4_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] lcd_db,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_en
);
  logic       en_d;
  logic [3:0] nfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      nfall <= '0;
    end else begin
      en_d <= lcd_en;
      if (en_d && !lcd_en && nfall != 4'd15) nfall <= nfall + 4'd1;
    end
  end

  p_rw_low_r10: assert property (@(posedge clk) disable iff (!rst_n) !lcd_rw);
  p_db_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en && $past(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs));
  p_db_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs));
  p_busy_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !req_ready);
  p_take_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_init_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nfall < 4'd14 |-> !req_ready);
endmodule

bind lcd4_seq lcd4_seq_chk u_lcd4_seq_chk (.*);

// File: tb/test_lcd4_seq.sv
module test_lcd4_seq;
  localparam int PWR = 200, W41 = 80, W1 = 25, NIB = 10, CLR = 40, HOME = 32, EN = 3, SU = 2;

  logic clk = 0, rst_n = 0, req_valid = 0, req_rs = 0;
  logic [7:0] req_byte = '0;
  logic req_ready, lcd_rs, lcd_rw, lcd_en;
  logic [3:0] lcd_db;

  lcd4_seq #(.PWR_CYC(PWR), .W4100_CYC(W41), .W100_CYC(W1), .NIB_CYC(NIB),
             .CLR_CYC(CLR), .HOME_CYC(HOME), .EN_CYC(EN), .SU_CYC(SU)) i_lcd4_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_byte(req_byte), .lcd_db(lcd_db), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_en(lcd_en));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int fall_t[64], fall_w[64];
  logic [4:0] fall_v[64];
  int nf = 0, rise_t = 0, rdy_t = 0;
  logic pen = 0, prs = 0, prdy = 0;
  logic [3:0] pdb = '0;
  bit rw_bad = 0, db_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (lcd_en && !pen) rise_t = cyc;
    if (lcd_en && pen && (lcd_db != pdb || lcd_rs != prs)) db_bad = 1;
    if (!lcd_en && pen && nf < 64) begin
      fall_t[nf] = cyc; fall_v[nf] = {prs, pdb}; fall_w[nf] = cyc - rise_t; nf++;
    end
    if (req_ready && !prdy) rdy_t = cyc;
    if (lcd_rw) rw_bad = 1;
    pen = lcd_en; pdb = lcd_db; prs = lcd_rs; prdy = req_ready;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] init_nib(int k);
    case (k)
      0, 1, 2: return 5'h03;
      3, 4:    return 5'h02;
      5, 7:    return 5'h08;
      9:       return 5'h01;
      11:      return 5'h06;
      13:      return 5'h0C;
      default: return 5'h00;
    endcase
  endfunction

  function automatic int init_hold(int k);
    if (k == 0) return W41;
    if (k == 1) return W1;
    if (k == 9) return NIB + CLR;
    return NIB;
  endfunction

  function automatic int exp_hold(logic rs, logic [7:0] b);
    if (!rs && b == 8'h01) return NIB + CLR;
    if (!rs && b[7:1] == 7'h01) return NIB + HOME;
    return NIB;
  endfunction

  task automatic wait_ready();
    while (!req_ready) begin @(negedge clk); #1; end
  endtask

  task automatic send(logic rs, logic [7:0] b);
    int idx, t;
    wait_ready();
    idx = nf; t = cyc;
    req_valid = 1; req_rs = rs; req_byte = b;
    @(negedge clk); #1;
    req_valid = 0;
    wait_ready();
    chk("R9 one request gives two strobes", nf - idx, 2);
    chk("R5 high nibble and rs", fall_v[idx], {rs, b[7:4]});
    chk("R5 low nibble and rs", fall_v[idx+1], {rs, b[3:0]});
    chk("R9 first strobe after accept", fall_t[idx], t + 1 + SU + EN);
    chk("R7 nibble spacing", fall_t[idx+1] - fall_t[idx], NIB + SU + EN);
    chk("R8 post-byte wait", rdy_t - fall_t[idx+1], exp_hold(rs, b));
    chk("R6 enable width", fall_w[idx+1], EN);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready low in reset", req_ready, 0);
    chk("R1 en low in reset", lcd_en, 0);
    chk("R1 rw low in reset", lcd_rw, 0);
    rst_n = 1;
    wait_ready();
    chk("R4 script nibble count", nf, 14);
    t = PWR + SU + EN;
    for (int k = 0; k < 14; k++) begin
      if (k < 4) begin
        chk("R2 preamble nibble", fall_v[k], init_nib(k));
        chk("R2 preamble timing", fall_t[k], t);
      end else begin
        chk("R3 command nibble", fall_v[k], init_nib(k));
        chk("R3 command timing", fall_t[k], t);
      end
      chk("R6 enable width in script", fall_w[k], EN);
      t = t + init_hold(k) + SU + EN;
    end
    chk("R4 ready after script", rdy_t, fall_t[13] + NIB);

    send(1'b0, 8'h01);
    send(1'b0, 8'h02);
    send(1'b0, 8'h03);
    send(1'b1, 8'h01);
    send(1'b1, 8'h02);
    send(1'b0, 8'h80);
    void'($urandom(32'h1cd4));
    for (int i = 0; i < 18; i++) begin
      logic [7:0] b;
      logic r;
      b = 8'($urandom % 256);
      r = 1'($urandom % 2);
      send(r, b);
    end
    chk("R10 rw never high", int'(rw_bad), 0);
    chk("R6 bus stable during enable", int'(db_bad), 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired, R4 ready never returned");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule